// File: doc/BRIEF.md
# CHS Sector Address Sequencer

This block turns the addressing bytes of a disk command block into a current cylinder/head/sector position. It checks that position against the configured drive geometry and produces a linear block number for a format with a fixed number of sectors per track. A controller pulses `load` when a command block has arrived. It then pulses `advance` once for each sector moved, and the block walks the position forward and counts down the remaining sectors.

The cylinder number is split across two bytes. The head positioner saturates at the last configured cylinder, so a request past the end of the disk leaves a mismatch between the requested and the actual cylinder, which is reported. A count byte of zero requests 256 sectors. The linear block number and the legality flags are registered and follow each load or advance by one cycle.

Top module: `chs_seq`

## Requirements
- R1: On `load`, the head is taken from `cmd_head_b[4:0]`, the drive select from `cmd_head_b[5]`, the sector from `cmd_sect_b[5:0]`, and the cylinder from `{cmd_sect_b[7:6], cmd_cyl_b[7:0]}`. Bits 7:6 of `cmd_head_b` have no effect on any output.
- R2: The sector count is `cmd_cnt_b`, with 0 meaning 256. `last_sec` is high while exactly one sector remains. `done` is high once the count has reached zero after a load.
- R3: `lba` = (requested cylinder × `cfg_heads` + head) × 17 + sector. It appears, with `lba_vld` high, one clock after the edge that takes a load or an advance, and `lba_vld` is low in the cycle between.
- R4: A sector number of 17 or more raises `addr_bad`.
- R5: A head number equal to or above `cfg_heads` raises `addr_bad`.
- R6: On load, `cur_cyl` takes the requested cylinder, limited to `cfg_cyls`−1. If the request exceeds that limit, `seek_err` is raised. A requested cylinder that differs from `cur_cyl` raises `addr_bad`. `sense` reads 0x15 on a seek error, otherwise 0x21 on an illegal address, otherwise 0x00.
- R7: Each advance adds one to the sector. Past 16 the sector returns to 0 and the head increments. When the head reaches `cfg_heads` it returns to 0 and the requested cylinder and `cur_cyl` both increment.
- R8: On advance, `cur_cyl` saturates at `cfg_cyls`−1 while the requested cylinder keeps counting, so that stepping off the last cylinder raises `addr_bad` with sense 0x21.
- R9: An advance with no sectors remaining changes no output. A load and an advance in the same cycle act as a load alone.
- R10: After reset, `lba`, `lba_vld`, `addr_bad`, `sense`, `seek_err`, `cur_cyl`, `last_sec` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Take a new command block |
| advance | input | 1 | One sector has been transferred |
| cmd_head_b | input | 8 | Head and drive-select byte |
| cmd_sect_b | input | 8 | Sector and cylinder high bits byte |
| cmd_cyl_b | input | 8 | Cylinder low bits byte |
| cmd_cnt_b | input | 8 | Sector count byte (0 = 256) |
| cfg_heads | input | 6 | Configured head count |
| cfg_cyls | input | 11 | Configured cylinder count |
| lba | output | 21 | Linear block number |
| lba_vld | output | 1 | `lba`, `addr_bad` and `sense` are current |
| addr_bad | output | 1 | Current address is illegal |
| sense | output | 8 | Error code for the current address |
| seek_err | output | 1 | Load asked for a cylinder past the end |
| cur_cyl | output | 10 | Head positioner cylinder |
| drv_sel | output | 1 | Drive select from the command block |
| last_sec | output | 1 | One sector remains |
| done | output | 1 | All requested sectors transferred |

## Verification
A corrupted sector, head or requested cylinder register shows on `lba` one cycle after the next load or advance. It usually also shows on `addr_bad`, because the three legality checks read the same registers. A wrong cylinder positioner shows immediately on `cur_cyl`, and one cycle later as a false or missing `addr_bad`. A wrong remaining count shows only at the end of a transfer, as `last_sec` or `done` arriving one advance early or late. For that reason the bench runs a full 256-sector transfer and checks the count at its end.

// File: rtl/chs_pkg.sv
package chs_pkg;
  localparam logic [7:0] SENSE_OK      = 8'h00;
  localparam logic [7:0] SENSE_SEEK    = 8'h15;
  localparam logic [7:0] SENSE_BADADDR = 8'h21;
endpackage

// File: rtl/chs_rst_sync.sv
module chs_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/chs_fld_dec.sv
module chs_fld_dec #(
  parameter int HEAD_W = 5,
  parameter int SEC_W  = 6,
  parameter int CYL_W  = 10,
  parameter int CNT_W  = 9
) (
  input  logic [7:0]        b_head,
  input  logic [7:0]        b_sect,
  input  logic [7:0]        b_cyl,
  input  logic [7:0]        b_cnt,
  output logic [HEAD_W-1:0] f_head,
  output logic              f_drv,
  output logic [SEC_W-1:0]  f_sec,
  output logic [CYL_W-1:0]  f_cyl,
  output logic [CNT_W-1:0]  f_cnt
);
  logic unused_bits;

  assign f_head = b_head[HEAD_W-1:0];
  assign f_drv  = b_head[HEAD_W];
  assign f_sec  = b_sect[SEC_W-1:0];
  assign f_cyl  = {b_sect[7:SEC_W], b_cyl};
  assign f_cnt  = (b_cnt == 8'd0) ? CNT_W'(256) : CNT_W'(b_cnt);
  assign unused_bits = &{1'b0, b_head[7:HEAD_W+1]};
endmodule

// File: rtl/chs_step.sv
module chs_step #(
  parameter int HEAD_W = 5,
  parameter int SEC_W  = 6,
  parameter int CYL_W  = 10,
  parameter int SPT    = 17
) (
  input  logic [SEC_W-1:0]  sec,
  input  logic [HEAD_W-1:0] head,
  input  logic [CYL_W-1:0]  trk,
  input  logic [CYL_W-1:0]  cyl,
  input  logic [HEAD_W:0]   cfg_heads,
  input  logic [CYL_W:0]    max_cyl,
  output logic [SEC_W-1:0]  sec_n,
  output logic [HEAD_W-1:0] head_n,
  output logic [CYL_W-1:0]  trk_n,
  output logic [CYL_W-1:0]  cyl_n
);
  logic [SEC_W-1:0] sec_inc;
  logic [HEAD_W:0]  head_inc;
  logic [CYL_W:0]   cyl_inc;

  always_comb begin
    sec_inc  = sec + 1'b1;
    head_inc = {1'b0, head} + 1'b1;
    cyl_inc  = {1'b0, cyl} + 1'b1;
    sec_n    = sec_inc;
    head_n   = head;
    trk_n    = trk;
    cyl_n    = cyl;
    if (sec_inc >= SEC_W'(SPT)) begin
      sec_n = '0;
      if (head_inc >= cfg_heads) begin
        head_n = '0;
        trk_n  = trk + 1'b1;
        cyl_n  = (cyl_inc > max_cyl) ? max_cyl[CYL_W-1:0] : cyl_inc[CYL_W-1:0];
      end else begin
        head_n = head_inc[HEAD_W-1:0];
      end
    end
  end
endmodule

// File: rtl/chs_lba.sv
module chs_lba
  import chs_pkg::*;
#(
  parameter int HEAD_W = 5,
  parameter int SEC_W  = 6,
  parameter int CYL_W  = 10,
  parameter int SPT    = 17,
  parameter int LBA_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [SEC_W-1:0]  sec,
  input  logic [HEAD_W-1:0] head,
  input  logic [CYL_W-1:0]  trk,
  input  logic [CYL_W-1:0]  cyl,
  input  logic [HEAD_W:0]   cfg_heads,
  input  logic              seek_err,
  output logic [LBA_W-1:0]  lba,
  output logic              bad,
  output logic [7:0]        sense
);
  logic [LBA_W-1:0] trk_sum, lin_d;
  logic             bad_d;
  logic [7:0]       sense_d;

  always_comb begin
    trk_sum = LBA_W'(trk) * LBA_W'(cfg_heads) + LBA_W'(head);
    lin_d   = trk_sum * LBA_W'(SPT) + LBA_W'(sec);
    bad_d   = (sec >= SEC_W'(SPT)) | ({1'b0, head} >= cfg_heads) | (trk != cyl);
    if (seek_err)   sense_d = SENSE_SEEK;
    else if (bad_d) sense_d = SENSE_BADADDR;
    else            sense_d = SENSE_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lba   <= '0;
      bad   <= 1'b0;
      sense <= SENSE_OK;
    end else if (en) begin
      lba   <= lin_d;
      bad   <= bad_d;
      sense <= sense_d;
    end
  end
endmodule

// File: rtl/chs_seq.sv
module chs_seq #(
  parameter  int HEAD_W = 5,
  parameter  int SEC_W  = 6,
  parameter  int CYL_W  = 10,
  parameter  int SPT    = 17,
  localparam int CNT_W  = 9,
  localparam int LBA_W  = CYL_W + HEAD_W + 1 + $clog2(SPT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [7:0]        cmd_head_b,
  input  logic [7:0]        cmd_sect_b,
  input  logic [7:0]        cmd_cyl_b,
  input  logic [7:0]        cmd_cnt_b,
  input  logic [HEAD_W:0]   cfg_heads,
  input  logic [CYL_W:0]    cfg_cyls,
  output logic [LBA_W-1:0]  lba,
  output logic              lba_vld,
  output logic              addr_bad,
  output logic [7:0]        sense,
  output logic              seek_err,
  output logic [CYL_W-1:0]  cur_cyl,
  output logic              drv_sel,
  output logic              last_sec,
  output logic              done
);
  logic              rst_n_s;
  logic [HEAD_W-1:0] f_head, st_head, head_q, head_d;
  logic              f_drv, drv_q, drv_d;
  logic [SEC_W-1:0]  f_sec, st_sec, sec_q, sec_d;
  logic [CYL_W-1:0]  f_cyl, st_trk, st_cyl, trk_q, trk_d, cyl_q, cyl_d, ld_cyl;
  logic [CNT_W-1:0]  f_cnt, cnt_q, cnt_d;
  logic [CYL_W:0]    max_cyl;
  logic              act_q, act_d, serr_q, serr_d, upd_q, upd_d, vld_q, vld_d;
  logic              ld_over, adv_ok;

  chs_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  chs_fld_dec #(.HEAD_W(HEAD_W), .SEC_W(SEC_W), .CYL_W(CYL_W), .CNT_W(CNT_W)) u_dec (
    .b_head(cmd_head_b), .b_sect(cmd_sect_b), .b_cyl(cmd_cyl_b), .b_cnt(cmd_cnt_b),
    .f_head(f_head), .f_drv(f_drv), .f_sec(f_sec), .f_cyl(f_cyl), .f_cnt(f_cnt)
  );

  chs_step #(.HEAD_W(HEAD_W), .SEC_W(SEC_W), .CYL_W(CYL_W), .SPT(SPT)) u_step (
    .sec(sec_q), .head(head_q), .trk(trk_q), .cyl(cyl_q),
    .cfg_heads(cfg_heads), .max_cyl(max_cyl),
    .sec_n(st_sec), .head_n(st_head), .trk_n(st_trk), .cyl_n(st_cyl)
  );

  chs_lba #(.HEAD_W(HEAD_W), .SEC_W(SEC_W), .CYL_W(CYL_W), .SPT(SPT), .LBA_W(LBA_W)) u_lba (
    .clk(clk), .rst_n(rst_n_s), .en(upd_q),
    .sec(sec_q), .head(head_q), .trk(trk_q), .cyl(cyl_q),
    .cfg_heads(cfg_heads), .seek_err(serr_q),
    .lba(lba), .bad(addr_bad), .sense(sense)
  );

  assign max_cyl = (cfg_cyls == '0) ? '0 : cfg_cyls - 1'b1;
  assign ld_over = {1'b0, f_cyl} > max_cyl;
  assign ld_cyl  = ld_over ? max_cyl[CYL_W-1:0] : f_cyl;
  assign adv_ok  = advance & act_q & (cnt_q != '0) & ~load;

  always_comb begin
    sec_d  = sec_q;
    head_d = head_q;
    trk_d  = trk_q;
    cyl_d  = cyl_q;
    drv_d  = drv_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    serr_d = serr_q;
    upd_d  = 1'b0;
    vld_d  = vld_q;
    if (load) begin
      sec_d  = f_sec;
      head_d = f_head;
      trk_d  = f_cyl;
      cyl_d  = ld_cyl;
      drv_d  = f_drv;
      cnt_d  = f_cnt;
      act_d  = 1'b1;
      serr_d = ld_over;
      upd_d  = 1'b1;
      vld_d  = 1'b0;
    end else if (adv_ok) begin
      sec_d  = st_sec;
      head_d = st_head;
      trk_d  = st_trk;
      cyl_d  = st_cyl;
      cnt_d  = cnt_q - 1'b1;
      upd_d  = 1'b1;
      vld_d  = 1'b0;
    end else if (upd_q) begin
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sec_q  <= '0;
      head_q <= '0;
      trk_q  <= '0;
      cyl_q  <= '0;
      drv_q  <= 1'b0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      serr_q <= 1'b0;
      upd_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      sec_q  <= sec_d;
      head_q <= head_d;
      trk_q  <= trk_d;
      cyl_q  <= cyl_d;
      drv_q  <= drv_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      serr_q <= serr_d;
      upd_q  <= upd_d;
      vld_q  <= vld_d;
    end
  end

  assign lba_vld  = vld_q;
  assign seek_err = serr_q;
  assign cur_cyl  = cyl_q;
  assign drv_sel  = drv_q;
  assign last_sec = act_q & (cnt_q == CNT_W'(1));
  assign done     = act_q & (cnt_q == '0);
endmodule

// File: rtl/chs_seq_chk.sv
module chs_seq_chk #(
  parameter int CYL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             advance,
  input logic [CYL_W:0]   cfg_cyls,
  input logic             lba_vld,
  input logic [7:0]       sense,
  input logic             seek_err,
  input logic [CYL_W-1:0] cur_cyl,
  input logic             last_sec,
  input logic             done
);
  AST_LOAD_HIDES_LBA: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !lba_vld); // R3
  AST_LBA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load ##1 (!load && !advance)) |=> lba_vld); // R3
  AST_CYL_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cfg_cyls != '0) |=> ({1'b0, cur_cyl} < $past(cfg_cyls))); // R6
  AST_SEEK_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    (lba_vld && seek_err) |-> (sense == 8'h15)); // R6
  AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (last_sec && advance && !load) |=> done); // R2
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> (done && $stable(cur_cyl))); // R9
endmodule

bind chs_seq chs_seq_chk #(.CYL_W(CYL_W)) u_chk (.*);

// File: tb/chs_seq_test.sv
`timescale 1ns/1ps
module chs_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load, advance;
  logic [7:0]  cmd_head_b, cmd_sect_b, cmd_cyl_b, cmd_cnt_b;
  logic [5:0]  cfg_heads;
  logic [10:0] cfg_cyls;
  logic [20:0] lba;
  logic        lba_vld, addr_bad, seek_err, drv_sel, last_sec, done;
  logic [7:0]  sense;
  logic [9:0]  cur_cyl;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  chs_seq uut (.*);

  typedef struct packed {
    logic [7:0]  b1, b2, b3;
    logic [23:0] lba;
    logic [7:0]  sense;
    logic        ill, serr, drv;
    logic [15:0] cyl;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{8'h02, 8'h03, 8'h05, 24'd377,   8'h00, 1'b0, 1'b0, 1'b0, 16'd5},
    '{8'hC1, 8'h50, 8'h10, 24'd18529, 8'h00, 1'b0, 1'b0, 1'b0, 16'd272},
    '{8'h00, 8'h11, 8'h00, 24'd17,    8'h21, 1'b1, 1'b0, 1'b0, 16'd0},
    '{8'h04, 8'h00, 8'h01, 24'd136,   8'h21, 1'b1, 1'b0, 1'b0, 16'd1},
    '{8'h00, 8'h80, 8'hBC, 24'd47600, 8'h15, 1'b1, 1'b1, 1'b0, 16'd614},
    '{8'h03, 8'h80, 8'h66, 24'd41803, 8'h00, 1'b0, 1'b0, 1'b0, 16'd614},
    '{8'h20, 8'h00, 8'h00, 24'd0,     8'h00, 1'b0, 1'b0, 1'b1, 16'd0}
  };

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] b1, b2, b3, b4, input logic adv);
    @(negedge clk);
    cmd_head_b = b1; cmd_sect_b = b2; cmd_cyl_b = b3; cmd_cnt_b = b4;
    load = 1'b1; advance = adv;
    @(negedge clk);
    load = 1'b0; advance = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_adv();
    @(negedge clk);
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; load = 1'b0; advance = 1'b0;
    cmd_head_b = '0; cmd_sect_b = '0; cmd_cyl_b = '0; cmd_cnt_b = '0;
    cfg_heads = 6'd4; cfg_cyls = 11'd615;
    repeat (3) @(negedge clk);
    chk("R10 lba", 32'(lba), 0);
    chk("R10 lba_vld", 32'(lba_vld), 0);
    chk("R10 addr_bad", 32'(addr_bad), 0);
    chk("R10 sense", 32'(sense), 0);
    chk("R10 seek_err", 32'(seek_err), 0);
    chk("R10 cur_cyl", 32'(cur_cyl), 0);
    chk("R10 last/done", 32'({last_sec, done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R3 R4 R5 R6 decode, linear block number, legality, seek limit
    foreach (VEC[i]) begin
      do_load(VEC[i].b1, VEC[i].b2, VEC[i].b3, 8'd1, 1'b0);
      chk("R3 lba", 32'(lba), 32'(VEC[i].lba));
      chk("R3 lba_vld", 32'(lba_vld), 1);
      chk("R4 R5 addr_bad", 32'(addr_bad), 32'(VEC[i].ill));
      chk("R6 sense", 32'(sense), 32'(VEC[i].sense));
      chk("R6 seek_err", 32'(seek_err), 32'(VEC[i].serr));
      chk("R6 cur_cyl", 32'(cur_cyl), 32'(VEC[i].cyl));
      chk("R1 drv_sel", 32'(drv_sel), 32'(VEC[i].drv));
      chk("R2 last_sec", 32'(last_sec), 1);
    end

    // R7 head and cylinder wrap: cyl 10 head 3 sector 16, three sectors
    do_load(8'h03, 8'h10, 8'h0A, 8'd3, 1'b0);
    chk("R7 start lba", 32'(lba), 747);
    do_adv();
    chk("R7 wrap lba", 32'(lba), 748);
    chk("R7 wrap cyl", 32'(cur_cyl), 11);
    chk("R7 wrap legal", 32'(addr_bad), 0);
    do_adv();
    chk("R2 last_sec", 32'(last_sec), 1);
    chk("R7 lba", 32'(lba), 749);
    do_adv();
    chk("R2 done", 32'(done), 1);
    chk("R2 last cleared", 32'(last_sec), 0);
    chk("R7 lba", 32'(lba), 750);
    do_adv();
    chk("R9 ignored lba", 32'(lba), 750);
    chk("R9 ignored vld", 32'(lba_vld), 1);
    chk("R9 ignored cyl", 32'(cur_cyl), 11);

    // R2 count byte 0 means 256
    do_load(8'h00, 8'h00, 8'h00, 8'd0, 1'b0);
    chk("R2 zero count not done", 32'(done), 0);
    @(negedge clk);
    advance = 1'b1;
    repeat (255) @(negedge clk);
    advance = 1'b0;
    @(negedge clk);
    chk("R2 255 lba", 32'(lba), 255);
    chk("R7 255 cyl", 32'(cur_cyl), 3);
    chk("R2 255 last", 32'(last_sec), 1);
    chk("R2 255 not done", 32'(done), 0);
    do_adv();
    chk("R2 256 done", 32'(done), 1);
    chk("R2 256 lba", 32'(lba), 256);

    // R8 stepping off the last cylinder
    do_load(8'h03, 8'h90, 8'h66, 8'd2, 1'b0);
    chk("R8 start lba", 32'(lba), 41819);
    chk("R8 start legal", 32'(addr_bad), 0);
    do_adv();
    chk("R8 cyl held", 32'(cur_cyl), 614);
    chk("R8 addr_bad", 32'(addr_bad), 1);
    chk("R8 sense", 32'(sense), 32'h21);
    chk("R8 lba", 32'(lba), 41820);

    // R9 load wins over a simultaneous advance
    do_load(8'h01, 8'h02, 8'h00, 8'd5, 1'b1);
    chk("R9 load priority lba", 32'(lba), 19);
    chk("R9 load priority last", 32'(last_sec), 0);
    chk("R6 seek_err cleared", 32'(seek_err), 0);
    for (int k = 0; k < 4; k++) do_adv();
    chk("R9 count intact", 32'(last_sec), 1);
    chk("R9 lba", 32'(lba), 23);

    finish_run();
  end
endmodule